// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Controller

This block collects the interrupt sources of a multichannel DMA engine into three groups: per-channel transmit completions, per-channel receive completions, and engine-level error conditions. For each group, software can read the raw source state and the state after masking. The mask of each group changes only through a pair of write ports. One port sets the mask bits written as one, and the other clears them, so no read-modify-write is needed.

The masked state of all groups feeds a single interrupt line toward the host. The line is gated by an arm flag. A host read of the vector register returns which groups are pending and disarms the line. A later end-of-interrupt write of zero re-arms it. The register interface is a simple single-cycle slave with registered read data.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset every group mask reads 0, irq_o is low and the line is armed.
- R2: A group's raw register (base +0x0) reads the level of its source inputs sampled one clock before the read is accepted.
- R3: Writing to a group's mask-set register (base +0x8) sets each mask bit whose written bit is 1; bits written as 0 keep their value.
- R4: Writing to a group's mask-clear register (base +0xC) clears each mask bit whose written bit is 1; bits written as 0 keep their value.
- R5: A group's masked register (base +0x4) reads raw AND mask. Both the mask-set and the mask-clear registers read back the current mask.
- R6: The group bases are 0x80 for transmit, 0xA0 for receive and 0xB0 for errors. Transmit and receive bit i belongs to channel i (NUM_CH=8 channels). The error group is ERR_W=2 bits wide, with bit 1 the host-error source. Register bits above a group's width read 0 and ignore writes.
- R7: While armed, irq_o is high exactly when some masked bit of any group is set. While disarmed, irq_o is low.
- R8: A read of 0x90 returns {29'b0, err_any, rx_any, tx_any}, where each bit is the OR of that group's masked bits. It disarms the line, so irq_o is low after that clock edge.
- R9: Writing 0 to 0x94 arms the line. irq_o follows the pending state from the next clock edge. A nonzero write to 0x94 is ignored.
- R10: Writes to raw, masked and vector addresses change nothing. Reads of unmapped addresses return 0.
- R11: rdata_o updates only on the clock edge that accepts a read and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid after the accepting edge |
| tx_src_i | input | NUM_CH | Transmit channel interrupt levels |
| rx_src_i | input | NUM_CH | Receive channel interrupt levels |
| err_src_i | input | ERR_W | Engine error levels, bit 1 host error |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The transmit mask is swept through all 256 values against a fixed raw pattern. This checks set readback, clear readback, masked value and the interrupt level together, and separates an AND from an OR or a swapped mask. The raw path is swept over all 256 source values, which exposes stuck or swapped channel bits and latency errors. Walking-one patterns on the receive group and all four error combinations check bit ownership and width truncation. Sequences of set, clear, vector read and end-of-interrupt writes, with zero and nonzero data, tell arm and disarm order apart from plain level gating.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 32;

  localparam logic [REG_AW-1:0] TX_BASE  = 8'h80;
  localparam logic [REG_AW-1:0] RX_BASE  = 8'hA0;
  localparam logic [REG_AW-1:0] ERR_BASE = 8'hB0;
  localparam logic [REG_AW-1:0] VEC_OFS  = 8'h90;
  localparam logic [REG_AW-1:0] EOI_OFS  = 8'h94;

  typedef enum logic [1:0] {
    SLOT_RAW    = 2'd0,
    SLOT_MASKED = 2'd1,
    SLOT_SET    = 2'd2,
    SLOT_CLR    = 2'd3
  } slot_e;

  typedef struct packed {
    logic  hit;
    slot_e slot;
  } grp_dec_t;

  function automatic grp_dec_t grp_decode(input logic [REG_AW-1:0] addr,
                                          input logic [REG_AW-1:0] base);
    grp_dec_t d;
    d.hit  = (addr[REG_AW-1:4] == base[REG_AW-1:4]) && (addr[1:0] == 2'b00);
    d.slot = slot_e'(addr[3:2]);
    return d;
  endfunction
endpackage

// File: rtl/irq_src_group.sv
module irq_src_group
  import dma_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDTH-1:0]  src_i,
  input  logic              wr_i,
  input  grp_dec_t          dec_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  raw_o,
  output logic [WIDTH-1:0]  mask_o,
  output logic [WIDTH-1:0]  masked_o,
  output logic [REG_DW-1:0] rd_o
);
  logic [WIDTH-1:0] raw_q, mask_q, mask_d;
  logic             set_en, clr_en;

  assign set_en = wr_i && dec_i.hit && (dec_i.slot == SLOT_SET);
  assign clr_en = wr_i && dec_i.hit && (dec_i.slot == SLOT_CLR);

  always_comb begin
    mask_d = mask_q;
    if (set_en) mask_d = mask_q | wdata_i;
    if (clr_en) mask_d = mask_q & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= src_i;
      mask_q <= mask_d;
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;

  always_comb begin
    rd_o = '0;
    unique case (dec_i.slot)
      SLOT_RAW:    rd_o[WIDTH-1:0] = raw_q;
      SLOT_MASKED: rd_o[WIDTH-1:0] = raw_q & mask_q;
      default:     rd_o[WIDTH-1:0] = mask_q;
    endcase
  end
endmodule

// File: rtl/irq_arm_ctrl.sv
module irq_arm_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eoi_i,
  input  logic ack_i,
  input  logic pending_i,
  output logic irq_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_q <= 1'b1;
    else if (eoi_i)  armed_q <= 1'b1;
    else if (ack_i)  armed_q <= 1'b0;
  end

  assign irq_o = armed_q & pending_i;
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ERR_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  input  logic [NUM_CH-1:0] tx_src_i,
  input  logic [NUM_CH-1:0] rx_src_i,
  input  logic [ERR_W-1:0]  err_src_i,
  output logic              irq_o
);
  localparam int unsigned NUM_GRP = 3;

  grp_dec_t          tx_dec, rx_dec, err_dec;
  logic              wr_en, rd_en, vec_rd, eoi_wr;
  logic [NUM_CH-1:0] tx_raw, tx_mask, tx_masked, rx_raw, rx_mask, rx_masked;
  logic [ERR_W-1:0]  err_raw, err_mask, err_masked;
  logic [REG_DW-1:0] tx_rd, rx_rd, err_rd, rd_d, rdata_q;
  logic [NUM_GRP-1:0] grp_any;
  logic              any_pending;

  assign wr_en   = req_i && we_i;
  assign rd_en   = req_i && !we_i;
  assign tx_dec  = grp_decode(addr_i, TX_BASE);
  assign rx_dec  = grp_decode(addr_i, RX_BASE);
  assign err_dec = grp_decode(addr_i, ERR_BASE);
  assign vec_rd  = rd_en && (addr_i == VEC_OFS);
  assign eoi_wr  = wr_en && (addr_i == EOI_OFS) && (wdata_i == '0);

  irq_src_group #(.WIDTH(NUM_CH)) u_tx (
    .clk_i, .rst_ni, .src_i(tx_src_i), .wr_i(wr_en), .dec_i(tx_dec),
    .wdata_i(wdata_i[NUM_CH-1:0]), .raw_o(tx_raw), .mask_o(tx_mask),
    .masked_o(tx_masked), .rd_o(tx_rd)
  );

  irq_src_group #(.WIDTH(NUM_CH)) u_rx (
    .clk_i, .rst_ni, .src_i(rx_src_i), .wr_i(wr_en), .dec_i(rx_dec),
    .wdata_i(wdata_i[NUM_CH-1:0]), .raw_o(rx_raw), .mask_o(rx_mask),
    .masked_o(rx_masked), .rd_o(rx_rd)
  );

  irq_src_group #(.WIDTH(ERR_W)) u_err (
    .clk_i, .rst_ni, .src_i(err_src_i), .wr_i(wr_en), .dec_i(err_dec),
    .wdata_i(wdata_i[ERR_W-1:0]), .raw_o(err_raw), .mask_o(err_mask),
    .masked_o(err_masked), .rd_o(err_rd)
  );

  assign grp_any     = {|err_masked, |rx_masked, |tx_masked};
  assign any_pending = |grp_any;

  irq_arm_ctrl u_arm (
    .clk_i, .rst_ni, .eoi_i(eoi_wr), .ack_i(vec_rd),
    .pending_i(any_pending), .irq_o
  );

  always_comb begin
    rd_d = '0;
    if (tx_dec.hit)            rd_d = tx_rd;
    else if (rx_dec.hit)       rd_d = rx_rd;
    else if (err_dec.hit)      rd_d = err_rd;
    else if (addr_i == VEC_OFS) rd_d[NUM_GRP-1:0] = grp_any;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [REG_AW-1:0] addr_i,
  input logic [REG_DW-1:0] wdata_i,
  input logic [REG_DW-1:0] rdata_o,
  input logic [NUM_CH-1:0] tx_src_i,
  input logic [NUM_CH-1:0] tx_raw_i,
  input logic [NUM_CH-1:0] tx_mask_i,
  input logic              any_pending_i,
  input logic              irq_o
);
  logic set_wr, clr_wr, ack_rd, eoi_wr;
  assign set_wr = req_i && we_i && (addr_i == TX_BASE + 8'h8);
  assign clr_wr = req_i && we_i && (addr_i == TX_BASE + 8'hC);
  assign ack_rd = req_i && !we_i && (addr_i == VEC_OFS);
  assign eoi_wr = req_i && we_i && (addr_i == EOI_OFS) && (wdata_i == '0);

  AST_RAW_FOLLOWS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (tx_raw_i == $past(tx_src_i))); // R2
  AST_SET_BITS_STICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr |=> ((tx_mask_i & $past(wdata_i[NUM_CH-1:0])) == $past(wdata_i[NUM_CH-1:0]))); // R3
  AST_CLR_BITS_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> ((tx_mask_i & $past(wdata_i[NUM_CH-1:0])) == '0)); // R4
  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> any_pending_i); // R7
  AST_ACK_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_rd |=> !irq_o); // R8
  AST_EOI_REARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_wr |=> (irq_o == any_pending_i)); // R9
  AST_RDATA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o)); // R11
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .tx_src_i(tx_src_i), .tx_raw_i(tx_raw),
  .tx_mask_i(tx_mask), .any_pending_i(any_pending), .irq_o(irq_o)
);

// File: tb/dma_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_irq_ctrl_tb_top;
  localparam int NUM_CH = 8;
  localparam int ERR_W  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [7:0]        addr = '0;
  logic [31:0]       wdata = '0, rdata;
  logic [NUM_CH-1:0] tx_src = '0, rx_src = '0;
  logic [ERR_W-1:0]  err_src = '0;
  logic              irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_irq_ctrl #(.NUM_CH(NUM_CH), .ERR_W(ERR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_src_i(tx_src), .rx_src_i(rx_src),
    .err_src_i(err_src), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, held;
    logic [7:0] pat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(8'h88, d); check("R1 tx mask", d, 32'h0);
    rd(8'hA8, d); check("R1 rx mask", d, 32'h0);
    rd(8'hBC, d); check("R1 err mask", d, 32'h0);

    // R2 raw sweep over all transmit source values
    for (int v = 0; v < 256; v++) begin
      @(negedge clk); tx_src = v[7:0];
      rd(8'h80, d); check("R2 tx raw", d, {24'b0, v[7:0]});
    end

    // R3 R4 R5 R7 mask sweep against fixed pattern, line armed from reset
    pat = 8'hA5;
    @(negedge clk); tx_src = pat;
    for (int m = 0; m < 256; m++) begin
      wr(8'h8C, 32'hFF);
      wr(8'h88, {24'b0, m[7:0]});
      rd(8'h88, d); check("R3 tx set readback", d, {24'b0, m[7:0]});
      rd(8'h8C, d); check("R5 tx clr readback", d, {24'b0, m[7:0]});
      rd(8'h84, d); check("R5 tx masked", d, {24'b0, pat & m[7:0]});
      check("R7 irq level", {31'b0, irq}, {31'b0, |(pat & m[7:0])});
    end

    // R3 R4 zero bits keep value
    wr(8'h8C, 32'hFF);
    wr(8'h88, 32'h0F); wr(8'h88, 32'hF0);
    rd(8'h88, d); check("R3 set accumulate", d, 32'hFF);
    wr(8'h8C, 32'h03);
    rd(8'h88, d); check("R4 clr partial", d, 32'hFC);
    wr(8'h8C, 32'hFF);

    // R6 receive walking one, channel i owns bit i
    for (int i = 0; i < NUM_CH; i++) begin
      @(negedge clk); rx_src = 8'(1 << i);
      wr(8'hAC, 32'hFF);
      wr(8'hA8, 32'(1 << i));
      rd(8'hA0, d); check("R6 rx raw bit", d, 32'(1 << i));
      rd(8'hA4, d); check("R6 rx masked bit", d, 32'(1 << i));
    end
    wr(8'hAC, 32'hFFFFFFFF);
    @(negedge clk); rx_src = '0;

    // R6 error group width and host-error bit
    wr(8'hB8, 32'hFFFFFFFF);
    rd(8'hB8, d); check("R6 err mask width", d, 32'h3);
    for (int e = 0; e < 4; e++) begin
      @(negedge clk); err_src = e[1:0];
      rd(8'hB0, d); check("R6 err raw", d, {30'b0, e[1:0]});
      rd(8'hB4, d); check("R6 err masked", d, {30'b0, e[1:0]});
    end
    wr(8'hBC, 32'h1);
    @(negedge clk); err_src = 2'b10;
    rd(8'hB4, d); check("R6 host error bit1", d, 32'h2);
    wr(8'hBC, 32'hFFFFFFFF);
    @(negedge clk); err_src = '0;

    // R7 all clear -> no interrupt
    wr(8'h8C, 32'hFFFFFFFF); wr(8'hAC, 32'hFFFFFFFF);
    @(negedge clk);
    check("R7 irq all masked", {31'b0, irq}, 32'h0);

    // R8 vector read and disarm
    @(negedge clk); tx_src = 8'h01; rx_src = 8'h80;
    wr(8'h88, 32'h01); wr(8'hA8, 32'h80);
    check("R7 irq armed pending", {31'b0, irq}, 32'h1);
    rd(8'h90, d); check("R8 vector", d, 32'h3);
    check("R8 irq after ack", {31'b0, irq}, 32'h0);

    // R9 nonzero eoi ignored, zero eoi re-arms
    wr(8'h94, 32'h1);
    check("R9 nonzero eoi ignored", {31'b0, irq}, 32'h0);
    wr(8'h94, 32'h0);
    check("R9 eoi rearms", {31'b0, irq}, 32'h1);

    // R7 armed with nothing pending, then source rises
    rd(8'h90, d);
    @(negedge clk); tx_src = '0; rx_src = '0;
    @(negedge clk);
    wr(8'h94, 32'h0);
    check("R9 eoi no pending", {31'b0, irq}, 32'h0);
    @(negedge clk); tx_src = 8'h01;
    @(negedge clk);
    check("R7 source rises while armed", {31'b0, irq}, 32'h1);

    // R10 writes to read-only addresses, unmapped read
    wr(8'h80, 32'hFF); wr(8'h84, 32'hFF); wr(8'h90, 32'hFF);
    rd(8'h88, d); check("R10 mask untouched", d, 32'h01);
    rd(8'h80, d); check("R10 raw untouched", d, 32'h01);
    check("R10 irq untouched", {31'b0, irq}, 32'h1);
    rd(8'h40, d); check("R10 unmapped read", d, 32'h0);

    // R11 read data holds without a read
    rd(8'h88, held);
    wr(8'h88, 32'hF0);
    repeat (3) @(negedge clk);
    check("R11 rdata hold", rdata, held);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule